// File: doc/BRIEF.md
# Dual-Byte Boundary-Scan Line Driver

This block is a pair of 9-bit non-inverting bus buffers with three-state outputs, wrapped in a 42-cell boundary-scan data register. In functional mode each byte copies its inputs to its output pins. A byte's outputs are switched on only while both of its active-low enable pins are low. The two pin enables of a byte are merged inside the block into one active-high enable.

A separate test access port controller supplies TCK and the capture, shift and update strobes for the data register. An instruction decoder supplies one mode line. The chain captures the input pins, the enable pins, the merged enables and the data the core presents to its outputs, and shifts these values from TDI to TDO. Cells on the outputs and on the merged enables also hold an update latch. While the mode line is high, these latches drive the pins in place of the core, so a board test can force known values.

The strobes are expected to change just after a rising TCK edge, as a TAP controller drives them.

Top module: `dualbyte_scan_buf`

## Requirements
- R1: The chain holds exactly 42 cells. While `dr_shift` is high and `dr_capture` is low, each rising TCK edge moves every cell one place toward TDO and loads cell 41 from `tdi`. `tdo` always shows cell 0, so a bit entered at `tdi` reaches `tdo` after 42 shifts.
- R2: With `test_mode` low, `pad_oe[b]` is 1 only when both `sys_en_n[2b]` and `sys_en_n[2b+1]` are 0. If either of these is 1, `pad_oe[b]` is 0.
- R3: With `test_mode` low, `pad_out` equals `sys_in` bit for bit, with no inversion, whatever the enables are.
- R4: With `test_mode` high, `pad_out` and `pad_oe` come only from the update latches. Changes on `sys_in` and `sys_en_n` have no effect on them.
- R5: An update latch loads its cell's shift stage on a falling TCK edge while `dr_update` is high. The new value is not visible at the pins before that falling edge.
- R6: With `test_mode` high, capturing and shifting without `dr_update` leave `pad_out` and `pad_oe` unchanged.
- R7: A rising TCK edge with `dr_capture` high loads the cells as follows. Cell 41-3b takes `sys_en_n[2b]` and cell 40-3b takes `sys_en_n[2b+1]`. Cell 39-3b takes the merged enable of byte b (1 = outputs on). Cell 35-(9b+i) takes `sys_in[9b+i]`. Cell 17-(9b+i) takes the core data for `pad_out[9b+i]`. Capture takes priority over shift.
- R8: In test mode, the latch of cell 39-3b drives `pad_oe[b]` and the latch of cell 17-(9b+i) drives `pad_out[9b+i]`. Cells on input pins and enable pins drive nothing.
- R9: While `tst_rst_n` is low, all shift stages and update latches clear at once, without waiting for a clock edge. In test mode this gives `pad_out` = 0, `pad_oe` = 0 and `tdo` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tst_rst_n | input | 1 | Asynchronous active-low scan reset |
| dr_capture | input | 1 | Capture strobe for the data register |
| dr_shift | input | 1 | Shift strobe for the data register |
| dr_update | input | 1 | Update strobe, acted on at the falling TCK edge |
| tdi | input | 1 | Serial test data in |
| test_mode | input | 1 | High: pins are driven from the update latches |
| sys_en_n | input | 4 | Active-low enable pins, two per byte (bits 2b and 2b+1 belong to byte b) |
| sys_in | input | 18 | Data inputs, byte b at bits 9b to 9b+8 |
| tdo | output | 1 | Serial test data out (cell 0) |
| pad_out | output | 18 | Output pin values |
| pad_oe | output | 2 | Active-high output enable per byte |

## Verification
On every TCK cycle, the assertions check the functional behaviour: outputs follow inputs, and any high enable pin turns its byte off. They also check that in test mode the pins hold still unless an update is pending. At the cell level, they check that each capture loads the parallel value, each shift moves one place, and each update copies the shift stage. Some behaviour is visible only at the ports, and only the bench's scenarios can show it. This covers the exact bit order of the 42-cell chain and the length as seen end to end. It also covers the half-cycle delay of the falling-edge update and the fact that input-side and enable-pin cells never reach a pin.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
// Chain geometry shared by the scan-wrapped dual-byte buffer.
package dbs_pkg;

   // Total cells: per byte two pin enables, one merged enable,
   // one observe cell per input and one control cell per output.
   function automatic int chain_len(input int nb, input int w);
      return nb * (3 + 2 * w);
   endfunction

   // Enable group of byte b: sel 0/1 = pin enables, sel 2 = merged enable.
   function automatic int en_pos(input int nb, input int w, input int b, input int sel);
      return chain_len(nb, w) - 1 - 3 * b - sel;
   endfunction

   function automatic int in_pos(input int nb, input int w, input int b, input int i);
      return chain_len(nb, w) - 3 * nb - 1 - (b * w + i);
   endfunction

   function automatic int out_pos(input int nb, input int w, input int b, input int i);
      return nb * w - 1 - (b * w + i);
   endfunction

endpackage

// File: rtl/dbs_byte_core.sv
`timescale 1ns/1ps
// Functional path of one byte: non-inverting buffer with merged enable.
module dbs_byte_core #(
   parameter int W = 9
) (
   input  logic [1:0]   en_n,
   input  logic [W-1:0] din,
   output logic         oe,
   output logic [W-1:0] dout
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dbs_byte_core: W must be at least 1");
      end
   endgenerate

   // Both active-low pins must be low to enable the byte.
   assign oe   = ~(en_n[0] | en_n[1]);
   assign dout = din;
endmodule

// File: rtl/dbs_obs_cell.sv
`timescale 1ns/1ps
// Observe-only scan cell: capture and shift, no system drive.
module dbs_obs_cell (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic par_in,
   input  logic ser_in,
   output logic ser_out
);
   logic stage_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      stage_q <= 1'b0;
      else if (cap_en) stage_q <= par_in;
      else if (shf_en) stage_q <= ser_in;
   end

   assign ser_out = stage_q;

   // R7: a capture loads the parallel value
   p_obs_capture_r7: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(cap_en) && $past(rst_n)) |-> (ser_out == $past(par_in)));

   // R1: a shift moves the upstream bit in
   p_obs_shift_r1: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(shf_en) && !$past(cap_en) && $past(rst_n)) |-> (ser_out == $past(ser_in)));
endmodule

// File: rtl/dbs_ctl_cell.sv
`timescale 1ns/1ps
// Control-capable scan cell: shift stage plus falling-edge update latch
// and a mode mux in front of the system pin.
module dbs_ctl_cell (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic upd_en,
   input  logic test_mode,
   input  logic par_in,
   input  logic ser_in,
   input  logic sys_val,
   output logic ser_out,
   output logic drv_out
);
   logic stage_q;
   logic hold_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      stage_q <= 1'b0;
      else if (cap_en) stage_q <= par_in;
      else if (shf_en) stage_q <= ser_in;
   end

   // Update on the falling edge, so the driven value never moves mid-shift.
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)      hold_q <= 1'b0;
      else if (upd_en) hold_q <= stage_q;
   end

   assign ser_out = stage_q;
   assign drv_out = test_mode ? hold_q : sys_val;

   // R7: a capture loads the core value
   p_ctl_capture_r7: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(cap_en) && $past(rst_n)) |-> (ser_out == $past(par_in)));

   // R1: a shift moves the upstream bit in
   p_ctl_shift_r1: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(shf_en) && !$past(cap_en) && $past(rst_n)) |-> (ser_out == $past(ser_in)));

   // R5: an update seen in this cycle means the pin shows the shift stage
   p_latch_load_r5: assert property (@(posedge tck) disable iff (!rst_n)
      (upd_en && test_mode && $past(rst_n)) |-> (drv_out == ser_out));

   // R6: without an update the driven test value holds
   p_latch_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
      (test_mode && $past(test_mode) && !upd_en && $past(rst_n)) |-> $stable(drv_out));
endmodule

// File: rtl/dualbyte_scan_buf.sv
`timescale 1ns/1ps
// Dual-byte non-inverting three-state buffer wrapped in a boundary-scan
// data register. Enable cells sit nearest TDI, output cells nearest TDO.
module dualbyte_scan_buf #(
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                          tck,
   input  logic                          tst_rst_n,
   input  logic                          dr_capture,
   input  logic                          dr_shift,
   input  logic                          dr_update,
   input  logic                          tdi,
   input  logic                          test_mode,
   input  logic [2*NUM_BYTES-1:0]        sys_en_n,
   input  logic [NUM_BYTES*BYTE_W-1:0]   sys_in,
   output logic                          tdo,
   output logic [NUM_BYTES*BYTE_W-1:0]   pad_out,
   output logic [NUM_BYTES-1:0]          pad_oe
);
   import dbs_pkg::*;

   localparam int CHAIN_LEN = chain_len(NUM_BYTES, BYTE_W);
   localparam int DATA_W    = NUM_BYTES * BYTE_W;

   generate
      if (BYTE_W < 1 || NUM_BYTES < 1) begin : g_bad_geom
         $error("dualbyte_scan_buf: BYTE_W and NUM_BYTES must be positive");
      end
   endgenerate

   // link[k+1] feeds cell k; link[CHAIN_LEN] is TDI, link[0] is TDO.
   logic [CHAIN_LEN:0]   link;
   logic [NUM_BYTES-1:0] core_oe;
   logic [DATA_W-1:0]    core_q;

   assign link[CHAIN_LEN] = tdi;
   assign tdo             = link[0];

   generate
      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
         localparam int PIN0 = en_pos(NUM_BYTES, BYTE_W, b, 0);
         localparam int PIN1 = en_pos(NUM_BYTES, BYTE_W, b, 1);
         localparam int MRG  = en_pos(NUM_BYTES, BYTE_W, b, 2);

         dbs_byte_core #(.W(BYTE_W)) u_core (
            .en_n (sys_en_n[2*b +: 2]),
            .din  (sys_in[b*BYTE_W +: BYTE_W]),
            .oe   (core_oe[b]),
            .dout (core_q[b*BYTE_W +: BYTE_W])
         );

         dbs_obs_cell u_pin0 (
            .tck(tck), .rst_n(tst_rst_n), .cap_en(dr_capture), .shf_en(dr_shift),
            .par_in(sys_en_n[2*b]), .ser_in(link[PIN0+1]), .ser_out(link[PIN0])
         );

         dbs_obs_cell u_pin1 (
            .tck(tck), .rst_n(tst_rst_n), .cap_en(dr_capture), .shf_en(dr_shift),
            .par_in(sys_en_n[2*b+1]), .ser_in(link[PIN1+1]), .ser_out(link[PIN1])
         );

         dbs_ctl_cell u_merged (
            .tck(tck), .rst_n(tst_rst_n), .cap_en(dr_capture), .shf_en(dr_shift),
            .upd_en(dr_update), .test_mode(test_mode),
            .par_in(core_oe[b]), .ser_in(link[MRG+1]), .sys_val(core_oe[b]),
            .ser_out(link[MRG]), .drv_out(pad_oe[b])
         );

         for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            localparam int IPOS = in_pos(NUM_BYTES, BYTE_W, b, i);
            localparam int OPOS = out_pos(NUM_BYTES, BYTE_W, b, i);

            dbs_obs_cell u_in (
               .tck(tck), .rst_n(tst_rst_n), .cap_en(dr_capture), .shf_en(dr_shift),
               .par_in(sys_in[b*BYTE_W+i]), .ser_in(link[IPOS+1]), .ser_out(link[IPOS])
            );

            dbs_ctl_cell u_out (
               .tck(tck), .rst_n(tst_rst_n), .cap_en(dr_capture), .shf_en(dr_shift),
               .upd_en(dr_update), .test_mode(test_mode),
               .par_in(core_q[b*BYTE_W+i]), .ser_in(link[OPOS+1]),
               .sys_val(core_q[b*BYTE_W+i]),
               .ser_out(link[OPOS]), .drv_out(pad_out[b*BYTE_W+i])
            );
         end

         // R2: any high enable pin turns the byte off in functional mode
         p_oe_off_r2: assert property (@(posedge tck) disable iff (!tst_rst_n)
            (!test_mode && (sys_en_n[2*b] || sys_en_n[2*b+1])) |-> !pad_oe[b]);
      end
   endgenerate

   // R3: functional mode passes data straight through
   p_follow_r3: assert property (@(posedge tck) disable iff (!tst_rst_n)
      !test_mode |-> (pad_out == sys_in));

   // R4: in test mode the core inputs cannot reach the pins
   p_ignore_core_r4: assert property (@(posedge tck) disable iff (!tst_rst_n)
      (test_mode && $past(test_mode) && !dr_update && $past(tst_rst_n) && !$stable(sys_in))
         |-> $stable(pad_out));
endmodule

// File: tb/dualbyte_scan_buf_bench.sv
`timescale 1ns/1ps
module dualbyte_scan_buf_bench;
   logic        tck = 1'b0;
   logic        tst_rst_n, dr_capture, dr_shift, dr_update, tdi, test_mode;
   logic [3:0]  sys_en_n;
   logic [17:0] sys_in;
   logic        tdo;
   logic [17:0] pad_out;
   logic [1:0]  pad_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 tck = ~tck;

   dualbyte_scan_buf u_dualbyte_scan_buf (
      .tck(tck), .tst_rst_n(tst_rst_n), .dr_capture(dr_capture), .dr_shift(dr_shift),
      .dr_update(dr_update), .tdi(tdi), .test_mode(test_mode), .sys_en_n(sys_en_n),
      .sys_in(sys_in), .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // {en_n[3:0], sys_in[17:0], exp_oe[1:0], exp_out[17:0]} for functional mode
   localparam logic [41:0] VEC [6] = '{
      {4'b0000, 18'h00000, 2'b11, 18'h00000},
      {4'b0000, 18'h3FFFF, 2'b11, 18'h3FFFF},
      {4'b0001, 18'h15555, 2'b10, 18'h15555},
      {4'b0100, 18'h2AAAA, 2'b01, 18'h2AAAA},
      {4'b1010, 18'h1F00F, 2'b00, 18'h1F00F},
      {4'b1100, 18'h03A5C, 2'b01, 18'h03A5C}
   };

   task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge tck);
      #1;
   endtask

   // Expected captured chain per R7
   function automatic logic [41:0] exp_cap(input logic [3:0] en, input logic [17:0] d);
      logic [41:0] v = '0;
      for (int b = 0; b < 2; b++) begin
         v[41-3*b] = en[2*b];
         v[40-3*b] = en[2*b+1];
         v[39-3*b] = ~(en[2*b] | en[2*b+1]);
      end
      for (int j = 0; j < 18; j++) begin
         v[35-j] = d[j];
         v[17-j] = d[j];
      end
      return v;
   endfunction

   // Chain image that drives given enables and outputs per R8
   function automatic logic [41:0] make_v(input logic [1:0] oe, input logic [17:0] o);
      logic [41:0] v = '0;
      v[39] = oe[0];
      v[36] = oe[1];
      for (int j = 0; j < 18; j++) v[17-j] = o[j];
      return v;
   endfunction

   task automatic shift_only(input logic [41:0] din, output logic [41:0] dout);
      dr_shift = 1'b1;
      for (int k = 0; k < 42; k++) begin
         dout[k] = tdo;
         tdi     = din[k];
         tick();
      end
      dr_shift = 1'b0;
      tdi      = 1'b0;
   endtask

   task automatic capture();
      dr_capture = 1'b1;
      tick();
      dr_capture = 1'b0;
   endtask

   task automatic update();
      dr_update = 1'b1;
      tick();
      dr_update = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [41:0] dout;
      logic [41:0] p1, d5, d6;
      tst_rst_n  = 1'b0;
      dr_capture = 1'b0;
      dr_shift   = 1'b0;
      dr_update  = 1'b0;
      tdi        = 1'b0;
      test_mode  = 1'b1;
      sys_en_n   = 4'b0000;
      sys_in     = 18'h3FFFF;
      repeat (3) tick();

      // R9: reset state in test mode
      chk("R9 pad_out in reset", 42'(pad_out), 42'h0);
      chk("R9 pad_oe in reset", 42'(pad_oe), 42'h0);
      chk("R9 tdo in reset", 42'(tdo), 42'h0);
      tst_rst_n = 1'b1;
      test_mode = 1'b0;
      tick();

      // R2, R3: functional mode table
      for (int v = 0; v < 6; v++) begin
         sys_en_n = VEC[v][41:38];
         sys_in   = VEC[v][37:20];
         #1;
         chk($sformatf("R2 enable vector %0d", v), 42'(pad_oe), 42'(VEC[v][19:18]));
         chk($sformatf("R3 data vector %0d", v), 42'(pad_out), 42'(VEC[v][17:0]));
         tick();
      end

      // R7: capture order and contents
      sys_en_n = 4'b1000;
      sys_in   = 18'h2A5C3;
      tick();
      capture();
      p1 = 42'h2B3C4D5E6F7;
      shift_only(p1, dout);
      chk("R7 captured chain", dout, exp_cap(4'b1000, 18'h2A5C3));

      // R1: exact chain length
      shift_only(42'h0, dout);
      chk("R1 42-cell delay", dout, p1);

      // R8: load test values, including noise in observe-only cells
      d5 = make_v(2'b01, 18'h3C0F5) | {6'b110110, 18'h25A5A, 18'h0};
      shift_only(d5, dout);
      update();
      test_mode = 1'b1;
      #1;
      chk("R8 test enables", 42'(pad_oe), 42'h1);
      chk("R8 test data", 42'(pad_out), 42'h3C0F5);

      // R4: core inputs ignored in test mode
      sys_in   = ~sys_in;
      sys_en_n = 4'b1111;
      #1;
      chk("R4 data after input change", 42'(pad_out), 42'h3C0F5);
      tick();
      chk("R4 enables after input change", 42'(pad_oe), 42'h1);

      // R6: capture and shift without update keep outputs
      capture();
      chk("R6 hold after capture", {pad_oe, pad_out}, {2'b01, 18'h3C0F5});
      d6 = make_v(2'b10, 18'h12F0A);
      shift_only(d6, dout);
      chk("R6 hold after shift", {pad_oe, pad_out}, {2'b01, 18'h3C0F5});

      // R5: update becomes visible only at the falling edge
      dr_update = 1'b1;
      #1;
      chk("R5 before falling edge", {pad_oe, pad_out}, {2'b01, 18'h3C0F5});
      #1;
      chk("R5 after falling edge", {pad_oe, pad_out}, {2'b10, 18'h12F0A});
      tick();
      dr_update = 1'b0;

      // R3: back to functional mode
      test_mode = 1'b0;
      sys_in    = 18'h0F0F0;
      sys_en_n  = 4'b0011;
      #1;
      chk("R3 data after leaving test mode", 42'(pad_out), 42'h0F0F0);
      chk("R2 enables after leaving test mode", 42'(pad_oe), 42'h2);

      // R9: asynchronous reset clears latches
      test_mode = 1'b1;
      tst_rst_n = 1'b0;
      #1;
      chk("R9 async clear of outputs", {pad_oe, pad_out}, 42'h0);
      chk("R9 async clear of tdo", 42'(tdo), 42'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule